// File: doc/BRIEF.md
# Lockable Watchdog Timer with Keyed Feed

The block is a watchdog timer that software has to refresh on a regular schedule. Refreshing takes two writes in a row to a feed register. If the refresh stops, a 24-bit down counter reaches zero and the block raises either a system reset request or an interrupt. A fixed prescaler divides the clock by four in front of the counter. The choice between reset and interrupt is set by a mode bit.

Software can turn the watchdog on but can never turn it off. A requested enable or mode change stays pending and takes hold only at the next complete feed. From then on, only a reset clears it. A feed sequence that is wrong or left unfinished while the watchdog runs has the same effect as a timeout. A sticky flag records that the watchdog asked for a reset. This flag survives the system reset that follows and is cleared only by power-on reset or by software. A debug-halt input freezes the count.

The bus is synchronous and uses a select, a write strobe and a 2-bit address. Its four registers are control (0), reload (1), feed (2) and current value (3). Reads return data combinationally. Every selected cycle counts as one access.

Top module: `wdog_lock`

## Requirements
- R1: After power-on reset, control reads 0, reload reads 0xFF, current value reads 0xFF, and both `wdt_rst_req` and `wdt_irq` are low.
- R2: A write to reload stores max(wdata[23:0], 0xFF). Bits 31:24 are dropped.
- R3: A valid feed is a write of 0xAA to the feed register (address 2), with the very next selected access being a write of 0x55 to the same register. Control bit 0 (enable) and bit 1 (reset mode) are set by writing 1 and read back as 0 until a valid feed. Before that feed the counter does not move.
- R4: Once enable or reset mode reads 1, writing 0 to those bits has no effect. Only `rst_n` or `por_n` clears them.
- R5: A valid feed loads the counter from reload and restarts the prescaler. From then on the value falls by one every 4 clock cycles.
- R6: In reset mode, with no further feed, `wdt_rst_req` rises exactly 4*(N+1) cycles after the feed's closing edge, where N is the reload value.
- R7: In interrupt mode, a timeout sets `wdt_irq` (control bit 3) and reloads the counter. Writing 1 to control bit 3 clears it.
- R8: While enabled, each of the following raises the same response as a timeout on the edge of the offending access: a feed write of any value other than 0xAA that does not follow an 0xAA write, 0xAA followed by an access that is not a 0x55 feed write, or 0xAA followed by another 0xAA. While not enabled, such writes raise nothing.
- R9: The flag (control bit 2) is set when the reset request is raised. It survives `rst_n`. It is cleared by writing 1 to bit 2 or by `por_n`.
- R10: While `dbg_halt` is high, the prescaler and counter are frozen, so the timeout moves later by exactly the number of halted cycles.
- R11: `wdt_rst_req` stays high until `rst_n` or `por_n` is asserted, even if a feed follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| por_n | input | 1 | Power-on reset, active low; also clears the flag |
| rst_n | input | 1 | System reset, active low; leaves the flag alone |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| dbg_halt | input | 1 | Freezes counting while high |
| wdt_rst_req | output | 1 | Sticky system reset request |
| wdt_irq | output | 1 | Interrupt request (pending bit) |

## Verification
The hardest condition to reach from the ports is a timeout landing on an exact cycle after a halt window in the middle of the count. The bench treats each task as exactly one clock cycle, so it knows the cycle index relative to the closing edge of a feed. It opens a debug-halt window of known length part-way through the count. It then samples the output one cycle before and at the predicted edge, 4*(N+1) plus the halt length. Broken feed sequences are built by following a first key with a read, a second first key or a wrong value, each while the watchdog is already locked on.

// File: rtl/wdog_lock_pkg.sv
package wdog_lock_pkg;

  typedef enum logic {
    FEED_IDLE  = 1'b0,
    FEED_ARMED = 1'b1
  } feed_state_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_RM_BIT   = 1;
  localparam int CTRL_FLAG_BIT = 2;
  localparam int CTRL_IRQ_BIT  = 3;

  // Lower bound applied to every reload write.
  function automatic logic [31:0] clamp_reload(input logic [31:0] val,
                                               input logic [31:0] floor_v);
    return (val < floor_v) ? floor_v : val;
  endfunction

  // Count step taken on a prescaler tick.
  function automatic logic [31:0] step_down(input logic [31:0] val);
    return val - 32'd1;
  endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clear_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] TOP = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;
  logic          at_top;

  assign at_top = (cnt_q == TOP);
  assign tick_o = run_i && at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (run_i)    cnt_q <= at_top ? '0 : cnt_q + PW'(1);
  end

  generate
    if (DIV > 1) begin : g_gap
      // R5
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/wdog_feed_seq.sv
module wdog_feed_seq
  import wdog_lock_pkg::*;
#(
  parameter logic [7:0] KEY_FIRST  = 8'hAA,
  parameter logic [7:0] KEY_SECOND = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_i,
  input  logic       feed_wr_i,
  input  logic [7:0] data_i,
  output logic       feed_ok_o,
  output logic       feed_bad_o
);
  feed_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    feed_ok_o  = 1'b0;
    feed_bad_o = 1'b0;
    if (acc_i) begin
      unique case (state_q)
        FEED_IDLE: begin
          if (feed_wr_i && data_i == KEY_FIRST) state_d = FEED_ARMED;
          else if (feed_wr_i)                   feed_bad_o = 1'b1;
        end
        FEED_ARMED: begin
          state_d = FEED_IDLE;
          if (feed_wr_i && data_i == KEY_SECOND) feed_ok_o  = 1'b1;
          else                                   feed_bad_o = 1'b1;
        end
        default: state_d = FEED_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FEED_IDLE;
    else        state_q <= state_d;
  end

  // R3
  feed_ok_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok_o |-> $past(feed_wr_i) && $past(acc_i));
  // R8
  feed_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(feed_ok_o && feed_bad_o));
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter
  import wdog_lock_pkg::*;
#(
  parameter int          CNT_W = 24,
  parameter logic [31:0] INIT  = 32'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o    = cnt_q;
  assign expire_o = tick_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= CNT_W'(INIT);
    else if (load_i || expire_o)  cnt_q <= load_val_i;
    else if (tick_i)              cnt_q <= CNT_W'(step_down(32'(cnt_q)));
  end

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load_i) && !$past(expire_o) && !$stable(cnt_q))
      |-> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/wdog_lock.sv
module wdog_lock
  import wdog_lock_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 2,
  parameter int          CNT_W      = 24,
  parameter int          PRE_DIV    = 4,
  parameter logic [31:0] MIN_RELOAD = 32'hFF,
  parameter logic [7:0]  KEY_FIRST  = 8'hAA,
  parameter logic [7:0]  KEY_SECOND = 8'h55
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_halt,
  output logic              wdt_rst_req,
  output logic              wdt_irq
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FEED   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_VALUE  = ADDR_W'(3);

  logic             sys_rst_n;
  logic             wr_ctrl, wr_reload, wr_feed;
  logic             feed_ok, feed_bad;
  logic             en_req_q, rm_req_q, en_act_q, rm_act_q;
  logic             irq_q, rreq_q, flag_q;
  logic [CNT_W-1:0] reload_q, count;
  logic             running, tick, expire, fault;

  assign sys_rst_n = rst_n & por_n;

  assign wr_ctrl   = bus_sel && bus_wr && (bus_addr == A_CTRL);
  assign wr_reload = bus_sel && bus_wr && (bus_addr == A_RELOAD);
  assign wr_feed   = bus_sel && bus_wr && (bus_addr == A_FEED);

  assign running = en_act_q && !dbg_halt;
  assign fault   = expire || (feed_bad && en_act_q);

  wdog_feed_seq #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) feed_i (
    .clk(clk), .rst_n(sys_rst_n), .acc_i(bus_sel), .feed_wr_i(wr_feed),
    .data_i(bus_wdata[7:0]), .feed_ok_o(feed_ok), .feed_bad_o(feed_bad)
  );

  wdog_prescaler #(.DIV(PRE_DIV)) pre_i (
    .clk(clk), .rst_n(sys_rst_n), .run_i(running), .clear_i(feed_ok),
    .tick_o(tick)
  );

  wdog_down_counter #(.CNT_W(CNT_W), .INIT(MIN_RELOAD)) cnt_i (
    .clk(clk), .rst_n(sys_rst_n), .load_i(feed_ok), .load_val_i(reload_q),
    .tick_i(tick), .cnt_o(count), .expire_o(expire)
  );

  // Control requests, lock-in on valid feed, reload register.
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      en_req_q <= 1'b0;
      rm_req_q <= 1'b0;
      en_act_q <= 1'b0;
      rm_act_q <= 1'b0;
      reload_q <= CNT_W'(MIN_RELOAD);
    end else begin
      if (wr_ctrl && bus_wdata[CTRL_EN_BIT]) en_req_q <= 1'b1;
      if (wr_ctrl && bus_wdata[CTRL_RM_BIT]) rm_req_q <= 1'b1;
      if (feed_ok && en_req_q) en_act_q <= 1'b1;
      if (feed_ok && rm_req_q) rm_act_q <= 1'b1;
      if (wr_reload)
        reload_q <= CNT_W'(clamp_reload(32'(bus_wdata[CNT_W-1:0]), MIN_RELOAD));
    end
  end

  // Response to a fault.
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      rreq_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (fault && rm_act_q) rreq_q <= 1'b1;
      if (fault && !rm_act_q)                    irq_q <= 1'b1;
      else if (wr_ctrl && bus_wdata[CTRL_IRQ_BIT]) irq_q <= 1'b0;
    end
  end

  // Flag lives in the power-on domain only.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                                   flag_q <= 1'b0;
    else if (fault && rm_act_q && sys_rst_n)      flag_q <= 1'b1;
    else if (wr_ctrl && bus_wdata[CTRL_FLAG_BIT]) flag_q <= 1'b0;
  end

  assign wdt_rst_req = rreq_q;
  assign wdt_irq     = irq_q;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CTRL:   bus_rdata = DATA_W'({irq_q, flag_q, rm_act_q, en_act_q});
      A_RELOAD: bus_rdata = DATA_W'(reload_q);
      A_FEED:   bus_rdata = '0;
      A_VALUE:  bus_rdata = DATA_W'(count);
      default:  bus_rdata = '0;
    endcase
  end

  // R4
  enable_lock_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    en_act_q |=> en_act_q);
  // R11
  rst_req_sticky_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    wdt_rst_req |=> wdt_rst_req);
  // R8
  bad_feed_resp_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (feed_bad && en_act_q) |=> (wdt_rst_req || wdt_irq));
  // R9
  flag_with_req_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $rose(wdt_rst_req) |-> flag_q);
  // R10
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (dbg_halt && !feed_ok) |=> $stable(count));
endmodule

// File: tb/wdog_lock_tb_top.sv
module wdog_lock_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_halt = 1'b0;
  logic        wdt_rst_req, wdt_irq;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_lock dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
    .wdt_rst_req(wdt_rst_req), .wdt_irq(wdt_irq)
  );

  function automatic logic [31:0] exp_clamp(input logic [31:0] v);
    logic [31:0] low;
    low = v & 32'h00FF_FFFF;
    return (low < 32'd255) ? 32'd255 : low;
  endfunction

  function automatic int exp_delay(input int n);
    return DIV * (n + 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Each task begins and ends at a falling edge and spans one clock.
  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #(CLK_PERIOD/4);
    d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic feed();
    bus_write(2'd2, 32'hAA);
    bus_write(2'd2, 32'h55);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic power_on();
    por_n = 1'b0; rst_n = 1'b0;
    wait_cyc(3);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [31:0] rd;
    int n;
    @(negedge clk);
    power_on();

    // R1 reset state
    bus_read(2'd0, rd); check("R1 ctrl", rd, 32'h0);
    bus_read(2'd1, rd); check("R1 reload", rd, 32'hFF);
    bus_read(2'd3, rd); check("R1 value", rd, 32'hFF);
    check("R1 rst_req", {31'b0, wdt_rst_req}, 32'h0);
    check("R1 irq", {31'b0, wdt_irq}, 32'h0);

    // R2 clamp sweep around the floor plus outliers
    for (int v = 32'hF0; v <= 32'h10F; v++) begin
      bus_write(2'd1, 32'(v));
      bus_read(2'd1, rd); check("R2 clamp", rd, exp_clamp(32'(v)));
    end
    bus_write(2'd1, 32'h0);         bus_read(2'd1, rd); check("R2 zero", rd, exp_clamp(32'h0));
    bus_write(2'd1, 32'h12345678);  bus_read(2'd1, rd); check("R2 upper", rd, exp_clamp(32'h12345678));
    bus_write(2'd1, 32'hFFFFFF);    bus_read(2'd1, rd); check("R2 max", rd, exp_clamp(32'hFFFFFF));

    // R8 bad key while not enabled is ignored
    bus_write(2'd2, 32'h12);
    bus_write(2'd2, 32'hAA); bus_read(2'd0, rd);
    check("R8 idle irq", {31'b0, wdt_irq}, 32'h0);
    check("R8 idle rst", {31'b0, wdt_rst_req}, 32'h0);

    // R3 pending enable
    n = 32'h100;
    bus_write(2'd1, 32'(n));
    bus_write(2'd0, 32'h1);
    bus_read(2'd0, rd); check("R3 en pending", rd & 32'h3, 32'h0);
    wait_cyc(20);
    bus_read(2'd3, rd); check("R3 frozen", rd, 32'hFF);
    feed();
    bus_read(2'd3, rd); check("R5 loaded", rd, 32'(n));
    bus_read(2'd0, rd); check("R3 en active", rd & 32'h3, 32'h1);

    // R5 step every DIV cycles
    feed();
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      bus_read(2'd3, rd); check("R5 step", rd, 32'(n - k));
      wait_cyc(DIV - 1);
    end

    // R4 enable cannot be cleared
    bus_write(2'd0, 32'h0);
    bus_read(2'd0, rd); check("R4 lock", rd & 32'h1, 32'h1);

    // R7 interrupt-mode timeout
    feed();
    wait_cyc(exp_delay(n) - 1);
    check("R7 irq early", {31'b0, wdt_irq}, 32'h0);
    @(negedge clk);
    check("R7 irq edge", {31'b0, wdt_irq}, 32'h1);
    bus_read(2'd3, rd); check("R7 reloaded", rd, 32'(n));
    bus_read(2'd0, rd); check("R7 ctrl bit3", rd & 32'h8, 32'h8);
    bus_write(2'd0, 32'h8);
    check("R7 irq clear", {31'b0, wdt_irq}, 32'h0);

    // R10 halt window shifts the timeout
    feed();
    wait_cyc(10);
    dbg_halt = 1'b1;
    wait_cyc(37);
    dbg_halt = 1'b0;
    wait_cyc(exp_delay(n) + 37 - 47 - 1);
    check("R10 early", {31'b0, wdt_irq}, 32'h0);
    @(negedge clk);
    check("R10 edge", {31'b0, wdt_irq}, 32'h1);
    bus_write(2'd0, 32'h8);

    // R8 broken sequences while enabled
    feed();
    bus_write(2'd2, 32'hAA); bus_read(2'd0, rd);
    check("R8 key then read", {31'b0, wdt_irq}, 32'h1);
    bus_write(2'd0, 32'h8);
    check("R8 cleared", {31'b0, wdt_irq}, 32'h0);
    bus_write(2'd2, 32'h33);
    check("R8 wrong key", {31'b0, wdt_irq}, 32'h1);
    bus_write(2'd0, 32'h8);
    bus_write(2'd2, 32'hAA); bus_write(2'd2, 32'hAA);
    check("R8 double first key", {31'b0, wdt_irq}, 32'h1);
    bus_write(2'd0, 32'h8);

    // R3 pending reset mode
    bus_write(2'd0, 32'h2);
    bus_read(2'd0, rd); check("R3 rm pending", rd & 32'h2, 32'h0);
    feed();
    bus_read(2'd0, rd); check("R3 rm active", rd & 32'h2, 32'h2);

    // R6 reset-mode timeout
    feed();
    wait_cyc(exp_delay(n) - 1);
    check("R6 early", {31'b0, wdt_rst_req}, 32'h0);
    @(negedge clk);
    check("R6 edge", {31'b0, wdt_rst_req}, 32'h1);
    check("R6 no irq", {31'b0, wdt_irq}, 32'h0);
    bus_read(2'd0, rd); check("R9 flag set", rd & 32'h4, 32'h4);

    // R11 sticky
    wait_cyc(50);
    feed();
    check("R11 sticky", {31'b0, wdt_rst_req}, 32'h1);

    // R9 flag survives system reset; R4 lock cleared by reset
    rst_n = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 released", {31'b0, wdt_rst_req}, 32'h0);
    bus_read(2'd0, rd); check("R9 flag kept R4 unlocked", rd, 32'h4);
    bus_write(2'd0, 32'h4);
    bus_read(2'd0, rd); check("R9 flag w1c", rd, 32'h0);

    // R8 broken sequence in reset mode, then R9 por clears flag
    bus_write(2'd0, 32'h3);
    feed();
    bus_write(2'd2, 32'h00);
    check("R8 reset mode", {31'b0, wdt_rst_req}, 32'h1);
    bus_read(2'd0, rd); check("R9 flag again", rd & 32'h4, 32'h4);
    power_on();
    bus_read(2'd0, rd); check("R9 por clears", rd, 32'h0);
    check("R1 rst after por", {31'b0, wdt_rst_req}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule